// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block shifts a 16-bit fixed-point operand into a 32-bit result window. It can shift logically, shift arithmetically, scale a word down by a given exponent, find how many redundant sign bits a word carries, and normalize a word by removing those bits. Each operation is issued with a one-cycle strobe. The result and the exponent are captured in registers and can be read on the next cycle.

A high/low placement select puts the operand in the upper or the lower half of the 32-bit window, so wider values can be assembled piece by piece. An optional block-exponent register supports block floating-point. A group of words is scanned with the exponent operation, and the register keeps the smallest redundant-sign count seen since it was last cleared. Every word in the group can then be scaled by that one shared amount.

Top module: `norm_shifter_top`

## Requirements
- R1: Operation code 0 (logical) treats the 8-bit two's-complement count as a shift: a positive count shifts the 32-bit placed value left, and a negative count shifts it right by the magnitude. Vacated bits on either side are filled with zeros.
- R2: Operation code 1 (arithmetic) shifts left like R1 for a positive count. For a negative count it shifts right and fills the vacated upper bits with bit 31 of the placed value.
- R3: A shift magnitude of 32 or more saturates the result. A left shift, or a logical right shift, gives all zeros. An arithmetic right shift gives 32 copies of bit 31 of the placed value.
- R4: With `hi_sel`=1 the operand occupies result bits 31:16 and bits 15:0 are zero. With `hi_sel`=0 it occupies bits 15:0. The upper half is then zero for operation 0 and a copy of operand bit 15 for every other operation.
- R5: Operation code 4 (exponent) sets `exp_q` to the number of bits below bit 15 that equal bit 15 before the first differing bit (0 to 15). The result is the placed operand, unshifted.
- R6: Operation code 2 (normalize) shifts the placed operand left by its redundant-sign count from R5 and writes that count to `exp_q`.
- R7: Operation code 3 (denormalize) shifts arithmetically to the right by the count when the count is positive, and to the left by the magnitude when it is negative. Saturation follows R3.
- R8: On each exponent operation, `blk_exp` becomes the smaller of its current value and the new count. `blk_clr` sets it to 15. When `blk_clr` and an exponent operation arrive in the same cycle, `blk_exp` takes the new count.
- R9: `res_q` and `res_vld` reflect an operation issued with `issue`=1 one cycle later. Without `issue`, `res_vld` is 0 and `res_q`, `exp_q` and `blk_exp` hold their values. `exp_q` changes only on operations 2 and 4.
- R10: After reset, `res_q`=0, `exp_q`=0, `res_vld`=0 and `blk_exp`=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 exponent) |
| hi_sel | input | 1 | Place operand in upper half when 1 |
| shamt | input | 8 | Signed shift count |
| din | input | 16 | Operand |
| blk_clr | input | 1 | Reset block exponent to 15 |
| res_q | output | 32 | Registered result |
| exp_q | output | 4 | Registered exponent |
| res_vld | output | 1 | Result valid, one cycle after issue |
| blk_exp | output | 4 | Running minimum exponent |

## Verification
The result, the exponent and the valid flag are all due one register stage after the strobe. The block exponent likewise settles one edge after the exponent operation that updates it. The bench drives each operation on a falling edge and compares the outputs on the next falling edge, which falls between the single capturing rising edge and the next one. Hold behaviour is checked by dropping the strobe, changing every input, and comparing on the following falling edge.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_LOG   = 3'd0,
    OP_ARI   = 3'd1,
    OP_NORM  = 3'd2,
    OP_DENRM = 3'd3,
    OP_EXPO  = 3'd4
  } shf_op_e;
endpackage

// File: rtl/shf_lead_sign.sv
module shf_lead_sign #(
  parameter int DATA_W = 16,
  localparam int EXP_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  output logic [EXP_W-1:0]  nsign
);
  logic run;

  always_comb begin
    run   = 1'b1;
    nsign = '0;
    for (int i = DATA_W-2; i >= 0; i--) begin
      if (run && (d[i] == d[DATA_W-1])) nsign = nsign + 1'b1;
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int RES_W = 32,
  parameter int CW    = 9,
  localparam int AMT_W = $clog2(RES_W)
) (
  input  logic [RES_W-1:0]  src,
  input  logic signed [CW-1:0] sc,
  input  logic              arith,
  output logic [RES_W-1:0]  dout
);
  logic [CW-1:0]    mag;
  logic             go_left;
  logic             sat;
  logic             fill;
  logic [AMT_W-1:0] amt;
  logic [RES_W-1:0] lft [0:AMT_W];
  logic [RES_W-1:0] rgt [0:AMT_W];

  assign go_left = ~sc[CW-1];
  assign mag     = go_left ? sc : -sc;
  assign sat     = (mag >= CW'(RES_W));
  assign amt     = mag[AMT_W-1:0];
  assign fill    = arith & src[RES_W-1];
  assign lft[0]  = src;
  assign rgt[0]  = src;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign lft[k+1] = amt[k] ? {lft[k][RES_W-1-SH:0], {SH{1'b0}}} : lft[k];
    assign rgt[k+1] = amt[k] ? {{SH{fill}}, rgt[k][RES_W-1:SH]} : rgt[k];
  end

  always_comb begin
    if (go_left) dout = sat ? '0 : lft[AMT_W];
    else         dout = sat ? {RES_W{fill}} : rgt[AMT_W];
  end
endmodule

// File: rtl/norm_shifter_top.sv
module norm_shifter_top
  import shf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter bit HAS_BLK = 1'b1,
  localparam int RES_W  = 2*DATA_W,
  localparam int EXP_W  = $clog2(DATA_W),
  localparam int CW     = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic              hi_sel,
  input  logic [CNT_W-1:0]  shamt,
  input  logic [DATA_W-1:0] din,
  input  logic              blk_clr,
  output logic [RES_W-1:0]  res_q,
  output logic [EXP_W-1:0]  exp_q,
  output logic              res_vld,
  output logic [EXP_W-1:0]  blk_exp
);
  shf_op_e             opc;
  logic                ext;
  logic [RES_W-1:0]    placed;
  logic [EXP_W-1:0]    nsign;
  logic signed [CW-1:0] cnt_s;
  logic signed [CW-1:0] sc;
  logic                arith;
  logic [RES_W-1:0]    shifted;
  logic [RES_W-1:0]    res_d;
  logic [EXP_W-1:0]    exp_d;
  logic                res_en;
  logic                exp_en;

  assign opc    = shf_op_e'(op);
  assign ext    = (opc == OP_LOG) ? 1'b0 : din[DATA_W-1];
  assign placed = hi_sel ? {din, {DATA_W{1'b0}}} : {{DATA_W{ext}}, din};
  assign cnt_s  = {shamt[CNT_W-1], shamt};
  assign arith  = (opc != OP_LOG);

  shf_lead_sign #(.DATA_W(DATA_W)) i_lsd (
    .d     (din),
    .nsign (nsign)
  );

  always_comb begin
    unique case (opc)
      OP_NORM:  sc = CW'(nsign);
      OP_DENRM: sc = -cnt_s;
      default:  sc = cnt_s;
    endcase
  end

  shf_barrel #(.RES_W(RES_W), .CW(CW)) i_bar (
    .src   (placed),
    .sc    (sc),
    .arith (arith),
    .dout  (shifted)
  );

  always_comb begin
    res_d  = res_q;
    exp_d  = exp_q;
    res_en = 1'b0;
    exp_en = 1'b0;
    if (issue) begin
      case (opc)
        OP_LOG, OP_ARI, OP_DENRM: begin
          res_en = 1'b1;
          res_d  = shifted;
        end
        OP_NORM: begin
          res_en = 1'b1;
          exp_en = 1'b1;
          res_d  = shifted;
          exp_d  = nsign;
        end
        OP_EXPO: begin
          res_en = 1'b1;
          exp_en = 1'b1;
          res_d  = placed;
          exp_d  = nsign;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      exp_q   <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= issue;
      if (res_en) res_q <= res_d;
      if (exp_en) exp_q <= exp_d;
    end
  end

  if (HAS_BLK) begin : g_blk
    logic [EXP_W-1:0] blk_d;
    logic             blk_en;
    logic             upd;

    assign upd = issue && (opc == OP_EXPO);

    always_comb begin
      blk_en = upd | blk_clr;
      blk_d  = blk_exp;
      if (upd && (blk_clr || (nsign < blk_exp))) blk_d = nsign;
      else if (blk_clr)                          blk_d = EXP_W'(DATA_W-1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_exp <= EXP_W'(DATA_W-1);
      else if (blk_en) blk_exp <= blk_d;
    end

    p_blk_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !blk_clr) |=> (blk_exp <= $past(blk_exp)));
    p_blk_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && blk_clr) |=> (blk_exp == exp_q));
  end else begin : g_noblk
    assign blk_exp = EXP_W'(DATA_W-1);
  end

  p_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_vld);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!res_vld && $stable(res_q) && $stable(exp_q)));
  p_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opc == OP_NORM && hi_sel) |=>
      ((res_q == '0) || (res_q[RES_W-1] != res_q[RES_W-2])));
  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opc == OP_LOG && ($signed(shamt) >= 32 || $signed(shamt) <= -32)) |=>
      (res_q == '0));
endmodule

// File: tb/test_norm_shifter_top.sv
module test_norm_shifter_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [2:0]  op;
  logic        hi_sel;
  logic [7:0]  shamt;
  logic [15:0] din;
  logic        blk_clr;
  logic [31:0] res_q;
  logic [3:0]  exp_q;
  logic        res_vld;
  logic [3:0]  blk_exp;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  norm_shifter_top i_norm_shifter_top (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .hi_sel(hi_sel),
    .shamt(shamt), .din(din), .blk_clr(blk_clr), .res_q(res_q),
    .exp_q(exp_q), .res_vld(res_vld), .blk_exp(blk_exp)
  );

  function automatic int lsd(input logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] model(input logic [2:0] o, input logic h,
                                        input logic [7:0] c, input logic [15:0] d);
    logic [31:0] p;
    int n;
    int m;
    logic ext = (o == 3'd0) ? 1'b0 : d[15];
    p = h ? {d, 16'h0000} : {{16{ext}}, d};
    if (o == 3'd4) return p;
    if (o == 3'd2) n = lsd(d);
    else if (o == 3'd3) n = -int'($signed(c));
    else n = int'($signed(c));
    if (n >= 0) return (n >= 32) ? 32'h0 : (p << n);
    m = -n;
    if (o == 3'd0) return (m >= 32) ? 32'h0 : (p >> m);
    return (m >= 32) ? {32{p[31]}} : 32'($signed(p) >>> m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic h,
                     input logic [7:0] c, input logic [15:0] d);
    logic [3:0] e_prev = exp_q;
    issue = 1'b1; op = o; hi_sel = h; shamt = c; din = d;
    @(negedge clk);
    chk(req, res_q, model(o, h, c, d));
    chk("R9", {31'b0, res_vld}, 32'd1);
    if (o == 3'd2 || o == 3'd4) chk(req, {28'b0, exp_q}, 32'(lsd(d)));
    else chk("R9", {28'b0, exp_q}, {28'b0, e_prev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [12];
    logic [3:0] bmin;
    logic [31:0] hold_r;
    pats = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h1234,
             16'hA5C3, 16'h00F0, 16'hFF0F, 16'h4000, 16'hC000, 16'h0100};
    rst_n = 1'b0; issue = 1'b0; op = 3'd0; hi_sel = 1'b0; shamt = 8'd0;
    din = 16'h0; blk_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", res_q, 32'h0);
    chk("R10", {28'b0, exp_q}, 32'h0);
    chk("R10", {31'b0, res_vld}, 32'h0);
    chk("R10", {28'b0, blk_exp}, 32'd15);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R7: count sweep across operand patterns and placements
    for (int pi = 0; pi < 12; pi++)
      for (int h = 0; h < 2; h++)
        for (int c = -40; c <= 40; c++) begin
          run("R1", 3'd0, 1'(h), 8'(c), pats[pi]);
          run("R2", 3'd1, 1'(h), 8'(c), pats[pi]);
          run("R7", 3'd3, 1'(h), 8'(c), pats[pi]);
        end
    // R3 extremes of the count range
    run("R3", 3'd1, 1'b1, 8'h80, 16'h8001);
    run("R3", 3'd0, 1'b0, 8'h7F, 16'hFFFF);
    run("R3", 3'd3, 1'b0, 8'h80, 16'h8001);

    // R5 exponent over every operand, upper placement
    for (int v = 0; v < 65536; v++) run("R5", 3'd4, 1'b1, 8'd0, 16'(v));
    // R5 R4 lower placement, R6 normalize both placements
    for (int v = 0; v < 65536; v += 7) begin
      run("R5", 3'd4, 1'b0, 8'd0, 16'(v));
      run("R6", 3'd2, 1'b1, 8'd0, 16'(v));
      run("R6", 3'd2, 1'b0, 8'd0, 16'(v));
    end

    // R8 block exponent tracking
    issue = 1'b0; blk_clr = 1'b1;
    @(negedge clk);
    chk("R8", {28'b0, blk_exp}, 32'd15);
    blk_clr = 1'b0;
    bmin = 4'd15;
    for (int i = 0; i < 12; i++) begin
      run("R8", 3'd4, 1'b0, 8'd0, pats[i]);
      if (lsd(pats[i]) < bmin) bmin = 4'(lsd(pats[i]));
      chk("R8", {28'b0, blk_exp}, {28'b0, bmin});
    end
    run("R8", 3'd1, 1'b0, 8'd0, 16'h0000);
    chk("R8", {28'b0, blk_exp}, {28'b0, bmin});
    blk_clr = 1'b1;
    run("R8", 3'd4, 1'b0, 8'd0, 16'h0003);
    chk("R8", {28'b0, blk_exp}, 32'd13);
    blk_clr = 1'b0;

    // R9 hold without issue
    run("R9", 3'd0, 1'b1, 8'd3, 16'h1357);
    hold_r = res_q;
    issue = 1'b0; op = 3'd4; din = 16'h0001; shamt = 8'hF0; hi_sel = 1'b0;
    @(negedge clk);
    chk("R9", res_q, hold_r);
    chk("R9", {31'b0, res_vld}, 32'd0);
    chk("R9", {28'b0, blk_exp}, 32'd13);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule